// File: doc/BRIEF.md
# Mode-Dependent Address Strobe Selector

This block sits beside the bus interface of a processor that has a separate system-management execution mode. Every time the bus unit starts a cycle it raises a one-clock request together with the cycle's address and access kind. The selector then answers with exactly one of two address strobes: the ordinary strobe, which sends the cycle to main memory, or the management strobe, which tells the chipset that the cycle belongs to the private management-memory window.

The choice depends on four things. The first is whether the processor is currently in management mode. The second is whether the address falls inside a programmable window given by a base and a power-of-two size. The third is whether the cycle is an instruction fetch or a data read/write. The fourth is two control bits. One bit, the main-access override, lets management-mode data accesses reach main memory where it overlaps the window. The other, the window-access enable, lets normal-mode code reach the window.

Internally a window matcher and a decision table feed a three-state machine. ST_IDLE means no strobe is driven. ST_NORM drives the ordinary strobe for one cycle. ST_MGMT drives the management strobe for one cycle. Each state moves on every clock. A request with a normal-mode decision goes to ST_NORM, and a request with a management decision goes to ST_MGMT. With no request the machine goes to ST_IDLE. Back-to-back requests therefore give back-to-back strobes.

Top module: `mm_strobe_sel`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released with no request, both strobes are low.
- R2: An address hits the window when base <= addr < base + 2^size_log2. The base is aligned to the window size, and size_log2 may be any value from 0 to ADDR_W-1.
- R3: In management mode with the main-access override clear, any access inside the window gets the management strobe: fetch (code 2'b00), read (2'b01) or write (2'b10).
- R4: In management mode, any access outside the window gets the ordinary strobe, whether it is code or data.
- R5: In management mode with the main-access override set, data reads and writes inside the window get the ordinary strobe.
- R6: In management mode with the main-access override set, instruction fetches inside the window still get the management strobe.
- R7: In normal mode with the window-access enable set, fetches, reads and writes inside the window get the management strobe.
- R8: In normal mode with the window-access enable clear, every access gets the ordinary strobe, whatever the address.
- R9: Each request sampled at a rising edge produces exactly one strobe, one cycle wide, in the following cycle. The two strobes are never high together, no strobe appears without a request, and back-to-back requests are served every cycle.
- R10: The main-access override has no effect in normal mode, and the window-access enable has no effect in management mode.
- R11: The access code 2'b11 is handled as a data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_req | input | 1 | One-cycle bus cycle start request |
| cyc_addr | input | ADDR_W | Address of the cycle |
| cyc_acc | input | 2 | Access kind: 00 fetch, 01 read, 10 write, 11 write |
| in_mgmt | input | 1 | Processor is in management mode |
| rgn_base | input | ADDR_W | Window base, aligned to the window size |
| rgn_size_log2 | input | SZ_W | Log2 of the window size in bytes |
| main_mem_en | input | 1 | Main-access override for management-mode data |
| mgmt_acc_en | input | 1 | Window-access enable for normal mode |
| norm_stb | output | 1 | Ordinary address strobe |
| mgmt_stb | output | 1 | Management address strobe |

## Verification
On every clock the assertions check that the strobes are mutually exclusive. They also check that each request gets one strobe in the next cycle and no strobe appears otherwise. For aligned windows, using a separately computed window compare, they check the outcome of the rules for outside-window, fetch-inside, override-data and disabled-normal-mode accesses. The bench's full sweep over address, window size, mode, both control bits and all four access codes is what shows that the whole decision table is correct, including the exact window edges and the handling of the spare access code.

// File: rtl/mm_strobe_pkg.sv
package mm_strobe_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH     = 2'b00,
        ACC_READ      = 2'b01,
        ACC_WRITE     = 2'b10,
        ACC_WRITE_ALT = 2'b11
    } acc_t;

    typedef enum logic {
        SEL_NORMAL = 1'b0,
        SEL_MGMT   = 1'b1
    } sel_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_NORM = 2'b01,
        ST_MGMT = 2'b10
    } stb_state_t;

    function automatic logic is_code(input acc_t a);
        return a == ACC_FETCH;
    endfunction

endpackage

// File: rtl/mm_region_match.sv
module mm_region_match #(
    parameter int ADDR_W = 32,
    parameter int SZ_W   = $clog2(ADDR_W)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [SZ_W-1:0]   size_log2,
    output logic              hit
);
    logic [ADDR_W-1:0] bit_ok;

    // A bit below the window size is free; above it, it must equal the base.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        localparam logic [SZ_W:0] IDX = (SZ_W+1)'(i);
        assign bit_ok[i] = (IDX < {1'b0, size_log2}) || (addr[i] == base[i]);
    end

    assign hit = &bit_ok;
endmodule

// File: rtl/mm_strobe_decide.sv
module mm_strobe_decide
    import mm_strobe_pkg::*;
(
    input  logic in_mgmt,
    input  logic hit,
    input  acc_t acc,
    input  logic main_mem_en,
    input  logic mgmt_acc_en,
    output sel_t sel
);
    logic code;
    assign code = is_code(acc);

    always_comb begin
        sel = SEL_NORMAL;
        unique case ({in_mgmt, hit})
            2'b00, 2'b01: begin
                // normal mode: only the window-access enable opens the window
                sel = (hit && mgmt_acc_en) ? SEL_MGMT : SEL_NORMAL;
            end
            2'b10: begin
                sel = SEL_NORMAL;
            end
            2'b11: begin
                // code in the window always stays private; data may escape
                sel = (code || !main_mem_en) ? SEL_MGMT : SEL_NORMAL;
            end
            default: sel = SEL_NORMAL;
        endcase
    end
endmodule

// File: rtl/mm_strobe_fsm.sv
module mm_strobe_fsm
    import mm_strobe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  sel_t sel,
    output logic norm_stb,
    output logic mgmt_stb
);
    stb_state_t state, state_nx;

    always_comb begin
        state_nx = ST_IDLE;
        if (req) begin
            unique case (sel)
                SEL_NORMAL: state_nx = ST_NORM;
                SEL_MGMT:   state_nx = ST_MGMT;
                default:    state_nx = ST_NORM;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        norm_stb = 1'b0;
        mgmt_stb = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_NORM: norm_stb = 1'b1;
            ST_MGMT: mgmt_stb = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/mm_strobe_sel.sv
module mm_strobe_sel
    import mm_strobe_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SZ_W   = $clog2(ADDR_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_req,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [1:0]        cyc_acc,
    input  logic              in_mgmt,
    input  logic [ADDR_W-1:0] rgn_base,
    input  logic [SZ_W-1:0]   rgn_size_log2,
    input  logic              main_mem_en,
    input  logic              mgmt_acc_en,
    output logic              norm_stb,
    output logic              mgmt_stb
);
    logic hit;
    sel_t sel;
    acc_t acc;

    assign acc = acc_t'(cyc_acc);

    mm_region_match #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_match (
        .addr      (cyc_addr),
        .base      (rgn_base),
        .size_log2 (rgn_size_log2),
        .hit       (hit)
    );

    mm_strobe_decide u_decide (
        .in_mgmt     (in_mgmt),
        .hit         (hit),
        .acc         (acc),
        .main_mem_en (main_mem_en),
        .mgmt_acc_en (mgmt_acc_en),
        .sel         (sel)
    );

    mm_strobe_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (cyc_req),
        .sel      (sel),
        .norm_stb (norm_stb),
        .mgmt_stb (mgmt_stb)
    );
endmodule

// File: rtl/mm_strobe_sel_chk.sv
module mm_strobe_sel_chk #(
    parameter int ADDR_W = 32,
    parameter int SZ_W   = $clog2(ADDR_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_req,
    input logic [ADDR_W-1:0] cyc_addr,
    input logic [1:0]        cyc_acc,
    input logic              in_mgmt,
    input logic [ADDR_W-1:0] rgn_base,
    input logic [SZ_W-1:0]   rgn_size_log2,
    input logic              main_mem_en,
    input logic              mgmt_acc_en,
    input logic              norm_stb,
    input logic              mgmt_stb
);
    logic [ADDR_W:0] lo, span, hi, a_ext;
    logic            aligned, in_win, fetch;

    assign lo      = {1'b0, rgn_base};
    assign span    = (ADDR_W+1)'(1) << rgn_size_log2;
    assign hi      = lo + span;
    assign a_ext   = {1'b0, cyc_addr};
    assign aligned = ((lo & (span - 1'b1)) == '0);
    assign in_win  = (a_ext >= lo) && (a_ext < hi);
    assign fetch   = (cyc_acc == 2'b00);

    AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(norm_stb && mgmt_stb)); // R9
    AST_STB_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_req |=> (norm_stb || mgmt_stb)); // R9
    AST_NO_SPURIOUS_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_req |=> !(norm_stb || mgmt_stb)); // R9
    AST_MM_OUTSIDE_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_req && aligned && in_mgmt && !in_win) |=> norm_stb); // R4
    AST_MM_FETCH_PRIVATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_req && aligned && in_mgmt && in_win && fetch) |=> mgmt_stb); // R6
    AST_MM_DATA_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_req && aligned && in_mgmt && in_win && !fetch && main_mem_en) |=> norm_stb); // R5
    AST_NM_DISABLED_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_req && !in_mgmt && !mgmt_acc_en) |=> norm_stb); // R8
    AST_NM_WINDOW_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_req && aligned && !in_mgmt && mgmt_acc_en && in_win) |=> mgmt_stb); // R7
endmodule

bind mm_strobe_sel mm_strobe_sel_chk #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cyc_req       (cyc_req),
    .cyc_addr      (cyc_addr),
    .cyc_acc       (cyc_acc),
    .in_mgmt       (in_mgmt),
    .rgn_base      (rgn_base),
    .rgn_size_log2 (rgn_size_log2),
    .main_mem_en   (main_mem_en),
    .mgmt_acc_en   (mgmt_acc_en),
    .norm_stb      (norm_stb),
    .mgmt_stb      (mgmt_stb)
);

// File: tb/mm_strobe_sel_test.sv
module mm_strobe_sel_test;
    localparam int AW = 8;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cyc_req = 1'b0;
    logic [AW-1:0] cyc_addr = '0;
    logic [1:0]    cyc_acc = 2'b00;
    logic          in_mgmt = 1'b0;
    logic [AW-1:0] rgn_base = '0;
    logic [SW-1:0] rgn_size_log2 = '0;
    logic          main_mem_en = 1'b0;
    logic          mgmt_acc_en = 1'b0;
    logic          norm_stb, mgmt_stb;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mm_strobe_sel #(.ADDR_W(AW), .SZ_W(SW)) uut (
        .clk(clk), .rst_n(rst_n), .cyc_req(cyc_req), .cyc_addr(cyc_addr),
        .cyc_acc(cyc_acc), .in_mgmt(in_mgmt), .rgn_base(rgn_base),
        .rgn_size_log2(rgn_size_log2), .main_mem_en(main_mem_en),
        .mgmt_acc_en(mgmt_acc_en), .norm_stb(norm_stb), .mgmt_stb(mgmt_stb)
    );

    // R2: window test done with plain integer arithmetic
    function automatic bit win_hit(int a, int b, int s);
        return (a >= b) && (a < b + (1 << s));
    endfunction

    function automatic bit want_mgmt(bit mm, bit h, int acc, bit me, bit ae);
        if (mm) return h && (acc == 0 || !me);
        return ae && h;
    endfunction

    function automatic string rule_tag(bit mm, bit h, int acc, bit me);
        if (mm && !h) return "R4";
        if (mm && me && acc != 0) return "R5";
        if (mm && me) return "R6";
        if (mm) return "R3";
        if (h) return "R7";
        return "R8";
    endfunction

    task automatic check_pair(string tag, bit exp_n, bit exp_m);
        checks++;
        if (norm_stb !== exp_n || mgmt_stb !== exp_m) begin
            failures++;
            $display("FAIL %s: norm=%0b mgmt=%0b expected norm=%0b mgmt=%0b",
                     tag, norm_stb, mgmt_stb, exp_n, exp_m);
        end
    endtask

    // drive at a falling edge, check at the next falling edge
    task automatic one_req(string tag, int a, int acc, bit exp_m);
        cyc_req  = 1'b1;
        cyc_addr = AW'(a);
        cyc_acc  = 2'(acc);
        @(negedge clk);
        check_pair(tag, !exp_m, exp_m);
    endtask

    initial begin
        @(negedge clk);
        check_pair("R1", 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_pair("R1", 1'b0, 1'b0);

        // Full sweep: the mode, both bits and all access codes (R10, R11)
        for (int sz = 0; sz < 8; sz++) begin
            rgn_size_log2 = SW'(sz);
            rgn_base = AW'(((8'h5A + sz * 8'h31) >> sz) << sz);
            for (int cfg = 0; cfg < 8; cfg++) begin
                in_mgmt     = cfg[2];
                main_mem_en = cfg[1];
                mgmt_acc_en = cfg[0];
                for (int acc = 0; acc < 4; acc++) begin
                    for (int a = 0; a < 256; a++) begin
                        bit h;
                        h = win_hit(a, int'(rgn_base), sz);
                        one_req(rule_tag(in_mgmt, h, acc, main_mem_en), a, acc,
                                want_mgmt(in_mgmt, h, acc, main_mem_en, mgmt_acc_en));
                    end
                end
            end
        end

        // R9: request dropped -> strobes low, and stay low
        cyc_req = 1'b0;
        @(negedge clk);
        check_pair("R9", 1'b0, 1'b0);
        @(negedge clk);
        check_pair("R9", 1'b0, 1'b0);

        // R2: window edges, base 0x40 size 16
        rgn_base = 8'h40; rgn_size_log2 = 3'd4;
        in_mgmt = 1'b1; main_mem_en = 1'b0; mgmt_acc_en = 1'b0;
        one_req("R2", 8'h3F, 1, 1'b0);
        one_req("R2", 8'h40, 1, 1'b1);
        one_req("R2", 8'h4F, 1, 1'b1);
        one_req("R2", 8'h50, 1, 1'b0);
        // R11: code 11 inside the window with the override set acts as data
        main_mem_en = 1'b1;
        one_req("R11", 8'h44, 3, 1'b0);
        // R10: window-access enable ignored in management mode
        main_mem_en = 1'b0; mgmt_acc_en = 1'b1;
        one_req("R10", 8'h20, 0, 1'b0);
        // R10: override ignored in normal mode
        in_mgmt = 1'b0; main_mem_en = 1'b1; mgmt_acc_en = 1'b0;
        one_req("R10", 8'h44, 1, 1'b0);
        // R9: isolated request between idle cycles
        cyc_req = 1'b0;
        @(negedge clk);
        check_pair("R9", 1'b0, 1'b0);
        mgmt_acc_en = 1'b1;
        one_req("R9", 8'h41, 2, 1'b1);
        cyc_req = 1'b0;
        @(negedge clk);
        check_pair("R9", 1'b0, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule